// File: doc/BRIEF.md
# SPI Slave Ready Flow Control

This block produces the ready handshake pin of an SPI slave from the fill levels of a transmit FIFO and a receive FIFO. Each FIFO is eight bytes deep. A host side fills the transmit FIFO and drains the receive FIFO. A single transfer strobe stands in for the serial engine: on each strobe it takes one byte from the transmit FIFO and stores one incoming byte in the receive FIFO. Underflow and overflow on a strobe each set a sticky error flag.

The ready pin is used only when the block is configured as a slave with flow control enabled. In that mode, a two-bit watermark code chooses the point at which the slave drops ready. The slave drops ready when the transmit FIFO has drained far enough or the receive FIFO has filled far enough. A polarity bit chooses whether the pin is active-high or active-low. In any other configuration the pin stays at its ready level.

Configuration inputs are captured only while the enable input is low. The pin is registered, so it lags the FIFO levels by one clock.

Top module: `spi_slave_ready`

## Requirements
- R1: After reset, readyPin is 0, both levels are 0 and both error flags are 0. The captured configuration after reset is master, flow control off, watermark code 0, active-low.
- R2: Each FIFO returns bytes in first-in first-out order. A host push to a full transmit FIFO is dropped. A host pop from an empty receive FIFO leaves the level unchanged.
- R3: On each transfer strobe, the byte shown on xferTxData leaves the transmit FIFO, and xferRxData is stored at the tail of the receive FIFO.
- R4: A strobe while the transmit FIFO is empty sets underflowErr. The flag then stays 1 until reset.
- R5: A strobe while the receive FIFO holds 8 bytes sets overflowErr and drops the incoming byte. The flag then stays 1 until reset.
- R6: isMaster, flowEn, wmSel and activeHigh are captured on every clock edge at which enable is low. While enable is high, changes on these inputs have no effect.
- R7: Unless the captured configuration is slave (isMaster=0) with flowEn=1, readyPin sits at its ready level.
- R8: With wmSel=0, the slave is not ready when the transmit level is 0 or the receive level is 8.
- R9: With wmSel=1, the slave is not ready when the transmit level is 2 or less or the receive level is 6 or more.
- R10: With wmSel=2, the slave is not ready when the transmit level is 4 or less or the receive level is 4 or more.
- R11: wmSel=3 behaves the same as wmSel=0.
- R12: With activeHigh=1, the ready level is 1 and the not-ready level is 0. With activeHigh=0, the levels are inverted.
- R13: readyPin reflects a FIFO level change one clock edge after the edge that changed the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; configuration is captured while low |
| isMaster | input | 1 | 1 = master, 0 = slave |
| flowEn | input | 1 | Flow control enable |
| wmSel | input | 2 | Watermark code |
| activeHigh | input | 1 | Ready pin polarity; 1 = active-high |
| txPushValid | input | 1 | Host push into transmit FIFO |
| txPushData | input | 8 | Byte pushed by host |
| rxPopReq | input | 1 | Host pop from receive FIFO |
| rxPopData | output | 8 | Head byte of receive FIFO |
| xferStrobe | input | 1 | One byte transfer |
| xferRxData | input | 8 | Byte received on a transfer |
| xferTxData | output | 8 | Head byte of transmit FIFO |
| txLevel | output | 4 | Transmit FIFO occupancy |
| rxLevel | output | 4 | Receive FIFO occupancy |
| underflowErr | output | 1 | Sticky transmit underflow flag |
| overflowErr | output | 1 | Sticky receive overflow flag |
| readyPin | output | 1 | Ready handshake pin |

## Verification
Inputs are driven on the falling edge, so each push, pop or strobe takes effect at the next rising edge. The levels, the head bytes and the error flags can therefore be read at the falling edge after that. readyPin lags by one more rising edge, and the bench shows this by reading the old pin value at the first falling edge and the new value at the second. A configuration change passes through the capture register and then the pin register, so the bench waits at least two edges before it reads readyPin after changing configuration.

// File: rtl/spi_ready_pkg.sv
package spi_ready_pkg;

  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
  } fifoStrobes_t;

  typedef enum logic [1:0] {
    WM_EDGE    = 2'd0,
    WM_QUARTER = 2'd1,
    WM_HALF    = 2'd2,
    WM_RSVD    = 2'd3
  } wmCode_e;

  typedef struct packed {
    logic    isMaster;
    logic    flowEn;
    wmCode_e wmSel;
    logic    activeHigh;
  } readyCfg_t;

endpackage

// File: rtl/spi_ready_fifo.sv
module spi_ready_fifo #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pop,
  output logic [DATA_W-1:0] headData,
  output logic [CNT_W-1:0]  level
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign headData = mem[rdPtr];

  // R2
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (level != CNT_W'(DEPTH)));

  // R2
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> (level != '0));

endmodule

// File: rtl/spi_ready_datapath.sv
module spi_ready_datapath
  import spi_ready_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobes_t      strb,
  input  logic [DATA_W-1:0] txPushData,
  input  logic [DATA_W-1:0] xferRxData,
  output logic [DATA_W-1:0] xferTxData,
  output logic [DATA_W-1:0] rxPopData,
  output logic [CNT_W-1:0]  txLevel,
  output logic [CNT_W-1:0]  rxLevel
);

  spi_ready_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_txFifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strb.txPush),
    .pushData (txPushData),
    .pop      (strb.txPop),
    .headData (xferTxData),
    .level    (txLevel)
  );

  spi_ready_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_rxFifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strb.rxPush),
    .pushData (xferRxData),
    .pop      (strb.rxPop),
    .headData (rxPopData),
    .level    (rxLevel)
  );

endmodule

// File: rtl/spi_ready_control.sv
module spi_ready_control
  import spi_ready_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  readyCfg_t        cfgIn,
  input  logic             txPushValid,
  input  logic             rxPopReq,
  input  logic             xferStrobe,
  input  logic [CNT_W-1:0] txLevel,
  input  logic [CNT_W-1:0] rxLevel,
  output fifoStrobes_t     strb,
  output logic             underflowErr,
  output logic             overflowErr,
  output logic             readyPin
);

  localparam logic [CNT_W-1:0] FULL_LVL  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] QTR_LVL   = CNT_W'(DEPTH / 4);
  localparam logic [CNT_W-1:0] HALF_LVL  = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] HIGH_LVL  = CNT_W'(DEPTH - DEPTH / 4);

  readyCfg_t cfgQ;
  logic      txEmpty, txFull, rxEmpty, rxFull;
  logic      gated, stall, pinNext;

  assign txEmpty = (txLevel == '0);
  assign txFull  = (txLevel == FULL_LVL);
  assign rxEmpty = (rxLevel == '0);
  assign rxFull  = (rxLevel == FULL_LVL);

  always_comb begin
    strb.txPush = txPushValid && !txFull;
    strb.txPop  = xferStrobe  && !txEmpty;
    strb.rxPush = xferStrobe  && !rxFull;
    strb.rxPop  = rxPopReq    && !rxEmpty;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '{isMaster: 1'b1, flowEn: 1'b0, wmSel: WM_EDGE, activeHigh: 1'b0};
    end else if (!enable) begin
      cfgQ <= cfgIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      underflowErr <= 1'b0;
      overflowErr  <= 1'b0;
    end else begin
      if (xferStrobe && txEmpty) underflowErr <= 1'b1;
      if (xferStrobe && rxFull)  overflowErr  <= 1'b1;
    end
  end

  always_comb begin
    case (cfgQ.wmSel)
      WM_QUARTER: stall = (txLevel <= QTR_LVL)  || (rxLevel >= HIGH_LVL);
      WM_HALF:    stall = (txLevel <= HALF_LVL) || (rxLevel >= HALF_LVL);
      default:    stall = txEmpty || rxFull;
    endcase
  end

  assign gated   = !cfgQ.isMaster && cfgQ.flowEn;
  assign pinNext = (gated && stall) ? !cfgQ.activeHigh : cfgQ.activeHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) readyPin <= 1'b0;
    else       readyPin <= pinNext;
  end

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> $stable(cfgQ));

  // R7
  ungated_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ.isMaster || !cfgQ.flowEn) |=> (readyPin == $past(cfgQ.activeHigh)));

  // R4
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    underflowErr |=> underflowErr);

  // R5
  overflow_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xferStrobe && rxLevel == FULL_LVL) |=> overflowErr);

endmodule

// File: rtl/spi_slave_ready.sv
module spi_slave_ready
  import spi_ready_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              isMaster,
  input  logic              flowEn,
  input  logic [1:0]        wmSel,
  input  logic              activeHigh,
  input  logic              txPushValid,
  input  logic [DATA_W-1:0] txPushData,
  input  logic              rxPopReq,
  output logic [DATA_W-1:0] rxPopData,
  input  logic              xferStrobe,
  input  logic [DATA_W-1:0] xferRxData,
  output logic [DATA_W-1:0] xferTxData,
  output logic [CNT_W-1:0]  txLevel,
  output logic [CNT_W-1:0]  rxLevel,
  output logic              underflowErr,
  output logic              overflowErr,
  output logic              readyPin
);

  fifoStrobes_t strb;
  readyCfg_t    cfgIn;

  assign cfgIn = '{isMaster: isMaster, flowEn: flowEn,
                   wmSel: wmCode_e'(wmSel), activeHigh: activeHigh};

  spi_ready_control #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_control (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .cfgIn        (cfgIn),
    .txPushValid  (txPushValid),
    .rxPopReq     (rxPopReq),
    .xferStrobe   (xferStrobe),
    .txLevel      (txLevel),
    .rxLevel      (rxLevel),
    .strb         (strb),
    .underflowErr (underflowErr),
    .overflowErr  (overflowErr),
    .readyPin     (readyPin)
  );

  spi_ready_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .txPushData (txPushData),
    .xferRxData (xferRxData),
    .xferTxData (xferTxData),
    .rxPopData  (rxPopData),
    .txLevel    (txLevel),
    .rxLevel    (rxLevel)
  );

endmodule

// File: tb/spi_slave_ready_bench.sv
`timescale 1ns/1ps
module spi_slave_ready_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0, isMaster = 1'b1, flowEn = 1'b0, activeHigh = 1'b0;
  logic [1:0] wmSel = 2'd0;
  logic       txPushValid = 1'b0, rxPopReq = 1'b0, xferStrobe = 1'b0;
  logic [7:0] txPushData = '0, xferRxData = '0;
  logic [7:0] rxPopData, xferTxData;
  logic [3:0] txLevel, rxLevel;
  logic       underflowErr, overflowErr, readyPin;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  spi_slave_ready u_spi_slave_ready (
    .clk(clk), .rstN(rstN), .enable(enable), .isMaster(isMaster), .flowEn(flowEn),
    .wmSel(wmSel), .activeHigh(activeHigh), .txPushValid(txPushValid),
    .txPushData(txPushData), .rxPopReq(rxPopReq), .rxPopData(rxPopData),
    .xferStrobe(xferStrobe), .xferRxData(xferRxData), .xferTxData(xferTxData),
    .txLevel(txLevel), .rxLevel(rxLevel), .underflowErr(underflowErr),
    .overflowErr(overflowErr), .readyPin(readyPin)
  );

  typedef struct packed {
    logic       flow;
    logic       mst;
    logic [1:0] wm;
    logic       pol;
    logic [3:0] tx;
    logic [3:0] rx;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{1'b1, 1'b0, 2'd0, 1'b1, 4'd3, 4'd3, 1'b1, 4'd8},   // R8 neither edge
    '{1'b1, 1'b0, 2'd0, 1'b1, 4'd0, 4'd3, 1'b0, 4'd8},   // R8 tx empty
    '{1'b1, 1'b0, 2'd0, 1'b1, 4'd3, 4'd8, 1'b0, 4'd8},   // R8 rx full
    '{1'b1, 1'b0, 2'd1, 1'b1, 4'd2, 4'd0, 1'b0, 4'd9},   // R9 tx at 2
    '{1'b1, 1'b0, 2'd1, 1'b1, 4'd3, 4'd5, 1'b1, 4'd9},   // R9 just inside
    '{1'b1, 1'b0, 2'd1, 1'b1, 4'd3, 4'd6, 1'b0, 4'd9},   // R9 rx at 6
    '{1'b1, 1'b0, 2'd2, 1'b1, 4'd5, 4'd3, 1'b1, 4'd10},  // R10 just inside
    '{1'b1, 1'b0, 2'd2, 1'b1, 4'd4, 4'd0, 1'b0, 4'd10},  // R10 tx at 4
    '{1'b1, 1'b0, 2'd2, 1'b1, 4'd5, 4'd4, 1'b0, 4'd10},  // R10 rx at 4
    '{1'b1, 1'b0, 2'd2, 1'b0, 4'd5, 4'd3, 1'b0, 4'd12},  // R12 active-low ready
    '{1'b1, 1'b0, 2'd2, 1'b0, 4'd4, 4'd0, 1'b1, 4'd12},  // R12 active-low stall
    '{1'b1, 1'b0, 2'd3, 1'b1, 4'd0, 4'd3, 1'b0, 4'd11},  // R11 like code 0
    '{1'b1, 1'b0, 2'd3, 1'b1, 4'd1, 4'd3, 1'b1, 4'd11},  // R11 not like code 1
    '{1'b0, 1'b0, 2'd0, 1'b1, 4'd0, 4'd0, 1'b1, 4'd7},   // R7 flow off
    '{1'b1, 1'b1, 2'd0, 1'b1, 4'd0, 4'd0, 1'b1, 4'd7},   // R7 master
    '{1'b1, 1'b1, 2'd0, 1'b0, 4'd0, 4'd0, 1'b0, 4'd7}    // R7 master active-low
  };

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input int act, input int exp, input int req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; enable = 1'b0; isMaster = 1'b1; flowEn = 1'b0; wmSel = 2'd0;
    activeHigh = 1'b0; txPushValid = 1'b0; rxPopReq = 1'b0; xferStrobe = 1'b0;
    tick(2);
    rstN = 1'b1;
    tick(1);
  endtask

  task automatic pushTx(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      txPushValid = 1'b1; txPushData = 8'(base + i);
      tick(1);
    end
    txPushValid = 1'b0;
  endtask

  task automatic strobe(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      xferStrobe = 1'b1; xferRxData = 8'(base + i);
      tick(1);
    end
    xferStrobe = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    doReset();
    chk(readyPin, 0, 1, "pin after reset");
    chk(txLevel, 0, 1, "tx level after reset");
    chk(rxLevel, 0, 1, "rx level after reset");
    chk(underflowErr, 0, 1, "underflow after reset");
    chk(overflowErr, 0, 1, "overflow after reset");

    // table walk: R7..R12
    for (int v = 0; v < 16; v++) begin
      doReset();
      flowEn = VECS[v].flow; isMaster = VECS[v].mst;
      wmSel = VECS[v].wm; activeHigh = VECS[v].pol;
      pushTx(int'(VECS[v].rx), 16);
      strobe(int'(VECS[v].rx), 64);
      pushTx(int'(VECS[v].tx), 32);
      tick(2);
      chk(txLevel, int'(VECS[v].tx), int'(VECS[v].req), $sformatf("vector %0d tx level", v));
      chk(rxLevel, int'(VECS[v].rx), int'(VECS[v].req), $sformatf("vector %0d rx level", v));
      chk(readyPin, int'(VECS[v].exp), int'(VECS[v].req), $sformatf("vector %0d pin", v));
    end

    // R2 push into full tx dropped, order kept; R3 head leaves on strobe
    doReset();
    pushTx(9, 100);
    chk(txLevel, 8, 2, "tx level after 9 pushes");
    for (int i = 0; i < 8; i++) begin
      chk(xferTxData, 100 + i, 3, "tx head order");
      strobe(1, 200 + i);
    end
    chk(txLevel, 0, 3, "tx drained by strobes");
    chk(underflowErr, 0, 4, "no underflow on 8 strobes");
    for (int i = 0; i < 8; i++) begin
      chk(rxPopData, 200 + i, 3, "rx head order");
      rxPopReq = 1'b1; tick(1); rxPopReq = 1'b0;
    end
    chk(rxLevel, 0, 2, "rx drained");
    rxPopReq = 1'b1; tick(1); rxPopReq = 1'b0;
    chk(rxLevel, 0, 2, "pop from empty rx ignored");

    // R4 underflow sticky
    doReset();
    strobe(1, 0);
    chk(underflowErr, 1, 4, "underflow set");
    tick(3);
    chk(underflowErr, 1, 4, "underflow held");

    // R5 overflow sticky, ninth byte dropped
    doReset();
    pushTx(8, 0);
    strobe(9, 40);
    chk(overflowErr, 1, 5, "overflow set");
    chk(rxLevel, 8, 5, "rx stays at 8");
    tick(3);
    chk(overflowErr, 1, 5, "overflow held");
    for (int i = 0; i < 8; i++) begin
      rxPopReq = 1'b1; tick(1);
    end
    rxPopReq = 1'b0;
    chk(rxLevel, 0, 5, "dropped byte not stored");

    // R6 config ignored while enabled
    doReset();
    isMaster = 1'b0; flowEn = 1'b1; wmSel = 2'd0; activeHigh = 1'b1;
    tick(3);
    chk(readyPin, 0, 6, "stall pin before enable");
    enable = 1'b1; activeHigh = 1'b0;
    tick(3);
    chk(readyPin, 0, 6, "polarity change ignored while enabled");
    enable = 1'b0;
    tick(3);
    chk(readyPin, 1, 6, "polarity taken after disable");

    // R13 pin lags level by one edge
    doReset();
    isMaster = 1'b0; flowEn = 1'b1; wmSel = 2'd0; activeHigh = 1'b1;
    tick(3);
    txPushValid = 1'b1; txPushData = 8'h5A;
    tick(1);
    txPushValid = 1'b0;
    chk(txLevel, 1, 13, "level updated");
    chk(readyPin, 0, 13, "pin not yet updated");
    tick(1);
    chk(readyPin, 1, 13, "pin updated one edge later");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule